// File: doc/BRIEF.md
# I2C Two-Channel Bus Switch Controller

This block is the digital core of a two-way I2C bus switch. It watches an upstream I2C bus through the system clock and behaves as a slave with one control register. A bus master writes that register to choose which of two downstream channels are connected. It reads the register back to see which channels are selected and which downstream interrupt lines are active. The outputs are two channel-enable levels, which drive the analog pass gates outside the block, and one combined active-low interrupt. Clock stretching is not supported.

The slave address is seven bits. The upper five bits come from a parameter (default `11100`) and the two lowest bits come from the `addr_sel` pins, so four of these switches can share one bus. A channel selection that has just been written is held in the register. It reaches `chan_en` only when a STOP condition appears, so a channel is never connected in the middle of a transfer. A synchronous active-low `rst_n` returns the block to its idle, deselected state.

Top module: `chsw_top`

## Requirements
- R1: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. A START from any state begins a new address byte.
- R2: The block acknowledges an address byte only when its upper seven bits (MSB first) equal {ADDR_HI, addr_sel}. For any other address it sends no acknowledge and ignores the bus until the next START, so a write that follows a non-matching address changes nothing.
- R3: Each data byte written after an acknowledged write address (address bit 0 = 0) is stored into the register. When several bytes arrive in one transfer, the last one is kept.
- R4: Register bit 0 enables channel 0 and bit 1 enables channel 1, and both may be set at once. `chan_en` changes only after a STOP condition.
- R5: After a read address (address bit 0 = 1), the block returns the byte {2'b00, ~irq_n_in[1], ~irq_n_in[0], reg[3:0]}. Written values of bits 7 to 4 never appear in the readback.
- R6: `irq_n_out` is low when either `irq_n_in` line is low and high when both are high. This holds whatever the channel selection is.
- R7: While `rst_n` is low at a clock edge, the register and `chan_en` are cleared and the bus logic returns to idle.
- R8: The block pulls SDA low in the acknowledge slot after a matching address and after each written byte. During a read, a master acknowledge brings out the status byte again. A master no-acknowledge makes the block release SDA.
- R9: `sda_oe` (1 = pull SDA low) changes only while SCL is low, except when it is cleared by a START or a STOP.
- R10: A repeated START inside a transfer restarts address reception and does not apply a pending channel write. The write is applied at the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_sel | input | 2 | Low two bits of the slave address |
| irq_n_in | input | 2 | Active-low interrupt from each channel |
| chan_en | output | 2 | Channel connect enables, bit i = channel i |
| irq_n_out | output | 1 | Active-low combined interrupt |

## Verification
The assertions assume that SCL and SDA each stay at a level for several system clocks, which is longer than the two-flop synchroniser plus the edge detector. They also assume that the master changes SDA only while SCL is low, except when it makes a START or a STOP. The bench respects both assumptions. It holds every quarter of an SCL period for six clocks and always moves SDA in the middle of the low phase. Its open-drain model ANDs the master's SDA with the inverse of `sda_oe`.

// File: rtl/chsw_pkg.sv
package chsw_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int SEL_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } link_st_t;
endpackage

// File: rtl/chsw_sync.sv
module chsw_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end
endmodule

// File: rtl/chsw_link.sv
module chsw_link
  import chsw_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11100,
  parameter int         PIN_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [PIN_W-1:0]  addr_sel,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              stop_stb
);
  localparam int ADDR_W = 5 + PIN_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  link_st_t          st;
  logic              scl_q, sda_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              rnw, m_ack;
  logic              start_c, stop_c, rise, fall;
  logic [ADDR_W-1:0] my_addr;

  assign my_addr = {ADDR_HI, addr_sel};
  assign start_c = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  assign rise    = scl_s & ~scl_q;
  assign fall    = ~scl_s & scl_q;
  assign wr_byte = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rnw      <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      stop_stb <= 1'b0;
    end else begin
      scl_q    <= scl_s;
      sda_q    <= sda_s;
      wr_stb   <= 1'b0;
      stop_stb <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        sda_oe   <= 1'b0;
        stop_stb <= 1'b1;
      end else begin
        unique case (st)
          ST_IDLE: ;
          ST_ADDR, ST_WDATA: begin
            if (rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == FULL) begin
              if (st == ST_WDATA) begin
                sda_oe <= 1'b1;
                wr_stb <= 1'b1;
                st     <= ST_WACK;
              end else if (sh[BYTE_W-1:1] == my_addr) begin
                sda_oe <= 1'b1;
                rnw    <= sh[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (fall) begin
              if (rnw) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_WACK: begin
            if (fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (rise) begin
              m_ack <= ~sda_s;
            end else if (fall) begin
              if (m_ack) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_AACK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK || st == ST_WACK) |-> sda_oe);  // R8
  AST_WDATA_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDATA || st == ST_RACK) |-> !sda_oe);  // R8
  AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_c || stop_c)));  // R9
  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |-> (st == ST_IDLE && !sda_oe));  // R1
endmodule

// File: rtl/chsw_regs.sv
module chsw_regs
  import chsw_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              stop_stb,
  input  logic [NCH-1:0]    irq_n_in,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [NCH-1:0]    chan_en,
  output logic              irq_n_out
);
  localparam int PAD_W = BYTE_W - SEL_W - NCH;

  logic [SEL_W-1:0] sel_q;
  logic [NCH-1:0]   irq_s;
  logic             unused_hi;

  assign unused_hi = ^wr_byte[BYTE_W-1:SEL_W];

  chsw_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (irq_n_in),
    .q    (irq_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      chan_en   <= '0;
      irq_n_out <= 1'b1;
    end else begin
      irq_n_out <= &irq_s;
      if (wr_stb)   sel_q   <= wr_byte[SEL_W-1:0];
      if (stop_stb) chan_en <= sel_q[NCH-1:0];
    end
  end

  assign rd_byte = {{PAD_W{1'b0}}, ~irq_s, sel_q};

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_stb |=> $stable(chan_en));  // R4
  AST_RST_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0 && sel_q == '0));  // R7
endmodule

// File: rtl/chsw_top.sv
module chsw_top
  import chsw_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b11100,
  parameter int         NCH         = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_in,
  input  logic           sda_in,
  output logic           sda_oe,
  input  logic [1:0]     addr_sel,
  input  logic [NCH-1:0] irq_n_in,
  output logic [NCH-1:0] chan_en,
  output logic           irq_n_out
);
  logic [1:0]        bus_s;
  logic              wr_stb, stop_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  chsw_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_in, sda_in}),
    .q    (bus_s)
  );

  chsw_link #(.ADDR_HI(ADDR_HI), .PIN_W(2)) u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s   (bus_s[1]),
    .sda_s   (bus_s[0]),
    .addr_sel(addr_sel),
    .rd_byte (rd_byte),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .stop_stb(stop_stb)
  );

  chsw_regs #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .stop_stb (stop_stb),
    .irq_n_in (irq_n_in),
    .rd_byte  (rd_byte),
    .chan_en  (chan_en),
    .irq_n_out(irq_n_out)
  );

  AST_WR_NOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && stop_stb));  // R3
endmodule

// File: tb/chsw_top_test.sv
module chsw_top_test;
  localparam int Q = 6;
  localparam logic [4:0] HI = 5'b11100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_sel = 2'd2;
  logic [1:0] irq_n_in = 2'b11;
  logic       sda_oe, irq_n_out;
  logic [1:0] chan_en;
  logic       sda_bus;
  int checks = 0, errors = 0, viol = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  chsw_top uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .irq_n_in(irq_n_in), .chan_en(chan_en), .irq_n_out(irq_n_out)
  );

  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe != oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q_wait(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    m_sda = 1; q_wait(); m_scl = 1; q_wait(); m_sda = 0; q_wait(); m_scl = 0; q_wait();
  endtask
  task automatic bus_stop();
    m_sda = 0; q_wait(); m_scl = 1; q_wait(); m_sda = 1; q_wait(); q_wait();
  endtask
  task automatic send_bit(input logic b);
    m_sda = b; q_wait(); m_scl = 1; q_wait(); q_wait(); m_scl = 0; q_wait();
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1; q_wait(); m_scl = 1; q_wait(); b = sda_bus; q_wait(); m_scl = 0; q_wait();
  endtask
  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask
  task automatic recv_byte(input bit ack_it, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    send_bit(!ack_it);
  endtask
  task automatic read_status(input string req, input logic [7:0] exp);
    bit ack; logic [7:0] v;
    bus_start();
    send_byte({HI, addr_sel, 1'b1}, ack);
    chk(ack, "R2 read addr ack", ack, 1);
    recv_byte(1'b0, v);
    chk(v == exp, req, v, exp);
    bus_stop();
  endtask
  task automatic write_one(input logic [7:0] v);
    bit ack;
    bus_start();
    send_byte({HI, addr_sel, 1'b0}, ack);
    send_byte(v, ack);
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] v, v2;
    logic [1:0] prev;
    repeat (4) @(negedge clk);
    chk(chan_en == 0 && irq_n_out == 1 && sda_oe == 0, "R7 reset state",
        {chan_en, irq_n_out, sda_oe}, 4'b0010);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1/R2: full address sweep with addr_sel = 2
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk(ack == (a == {HI, 2'd2}), "R1/R2 address sweep", ack, (a == {HI, 2'd2}));
      bus_stop();
    end
    // R2: each pin setting matches only its own address
    for (int p = 0; p < 4; p++) begin
      addr_sel = 2'(p);
      for (int a = 0; a < 4; a++) begin
        bus_start();
        send_byte({HI, 2'(a), 1'b0}, ack);
        chk(ack == (a == p), "R2 pin select", ack, (a == p));
        bus_stop();
      end
    end
    addr_sel = 2'd1;

    // R3/R4/R5/R8: write each low nibble with noisy upper bits
    prev = chan_en;
    for (int n = 0; n < 16; n++) begin
      v = {4'(n ^ 4'hA), 4'(n)};
      bus_start();
      send_byte({HI, addr_sel, 1'b0}, ack);
      chk(ack, "R8 addr ack", ack, 1);
      send_byte(v, ack);
      chk(ack, "R8 data ack", ack, 1);
      chk(chan_en == prev, "R4 no change before STOP", chan_en, prev);
      bus_stop();
      chk(chan_en == v[1:0], "R3/R4 applied at STOP", chan_en, v[1:0]);
      prev = chan_en;
      read_status("R5 readback ignores upper writes", {4'h0, 4'(n)});
    end

    // R3: several bytes, last kept
    bus_start();
    send_byte({HI, addr_sel, 1'b0}, ack);
    send_byte(8'h0D, ack); send_byte(8'h06, ack); send_byte(8'hF1, ack);
    chk(ack, "R8 third data ack", ack, 1);
    bus_stop();
    chk(chan_en == 2'b01, "R3 last byte kept", chan_en, 1);
    read_status("R3 last byte readback", 8'h01);

    // R6/R5: interrupt sweep with channels off
    write_one(8'h00);
    for (int i = 0; i < 4; i++) begin
      irq_n_in = 2'(i);
      repeat (8) @(negedge clk);
      chk(irq_n_out == &(2'(i)), "R6 irq and", irq_n_out, &(2'(i)));
      read_status("R5 irq bits", {2'b00, ~2'(i), 4'h0});
    end
    irq_n_in = 2'b11;

    // R8: read with master ack then nack, then release
    write_one(8'h03);
    bus_start();
    send_byte({HI, addr_sel, 1'b1}, ack);
    recv_byte(1'b1, v);
    recv_byte(1'b0, v2);
    chk(v == 8'h03 && v2 == 8'h03, "R8 repeated read", {v, v2}, 16'h0303);
    chk(sda_oe == 0, "R8 released after nack", sda_oe, 0);
    bus_stop();

    // R10: repeated START keeps pending write until STOP
    bus_start();
    send_byte({HI, addr_sel, 1'b0}, ack);
    send_byte(8'h02, ack);
    bus_start();
    chk(chan_en == 2'b11, "R10 no commit on repeated START", chan_en, 3);
    send_byte({HI, addr_sel, 1'b1}, ack);
    chk(ack, "R10 address after repeated START", ack, 1);
    recv_byte(1'b0, v);
    chk(v == 8'h02, "R10 pending value readable", v, 2);
    bus_stop();
    chk(chan_en == 2'b10, "R10 commit at STOP", chan_en, 2);

    // R2: non-matching write ignored
    bus_start();
    send_byte({HI, 2'd3, 1'b0}, ack);
    send_byte(8'h01, ack);
    chk(!ack, "R2 ignored data not acked", ack, 0);
    bus_stop();
    chk(chan_en == 2'b10, "R2 ignored write", chan_en, 2);
    read_status("R2 ignored write readback", 8'h02);

    // R7: reset clears selection
    write_one(8'h03);
    @(negedge clk); rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(chan_en == 0, "R7 reset clears channels", chan_en, 0);
    read_status("R7 reset clears register", 8'h00);

    chk(viol == 0, "R9 sda_oe moved with SCL high", viol, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule